// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block keeps the interrupt state of one processor for 256 vectors. Three 256-bit maps record which vectors are waiting, which are being serviced, and which arrived as level-triggered requests. Requests come in on an accept port and get an accepted or dropped answer. The block compares the highest waiting vector with the current processor priority and offers it to the processor through an acknowledge handshake.

The processor priority is the larger of two values: the task priority written by software, and the class of the highest vector in service. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, the block sends its number out on a broadcast port, so that the source that raised it can re-arm.

Bit position `v` of each map belongs to vector `v`: the upper three bits of the vector pick one of eight 32-bit words and the lower five bits pick the bit within that word. The priority class of a vector is its upper nibble (`vector & 0xF0`).

Top module: `vec_prio_arb`

## Requirements
- R1: After a synchronous active-low reset, the waiting, in-service and trigger maps and the task priority are clear. As a result `int_valid` is 0, `ppr` is 0 and `eoi_bcast_valid` is 0.
- R2: Each cycle with `req_valid` high yields exactly one of `req_accepted` or `req_dropped`, one cycle later. A cycle without a request yields neither. An accepted request sets the vector's waiting bit.
- R3: A request for a vector that is already waiting reports `req_dropped` and is not added again. A level-triggered duplicate leaves the trigger bit alone. An edge-triggered duplicate clears it, so a later retirement of that vector is not broadcast.
- R4: Requests for vectors 0 to 15 report `req_dropped` and never set a waiting bit.
- R5: Requests made while `hw_en` or `sw_en` is low report `req_dropped` and change no state.
- R6: `ppr` is `tpr[7:0]` when `tpr[7:4]` is greater than or equal to the class nibble of the highest in-service vector (0 when none is in service). Otherwise it is that class nibble followed by a zero low nibble. `ppr` takes its new value on the same clock edge that changes the task priority or the in-service map.
- R7: `int_valid` is 1 and `int_vec` equals the highest waiting vector only when `(vector & 0xF0) > ppr`. Otherwise both are 0. Both follow the current state combinationally.
- R8: `int_ack` while `int_valid` is 1 moves the offered vector from waiting to in-service on that edge. `int_ack` while `int_valid` is 0 has no effect.
- R9: `eoi` clears the highest in-service bit, and `ppr` is recomputed on the same edge. With nothing in service, `eoi` changes nothing.
- R10: When the vector retired by `eoi` has its trigger bit set, that bit is cleared, and in the next cycle `eoi_bcast_valid` is 1 for one cycle with `eoi_bcast_vec` equal to the vector. Retiring an edge-triggered vector gives no broadcast.
- R11: A `tpr_wr` keeps only bits [7:0] of the 32-bit `tpr_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable for accepting requests |
| sw_en | input | 1 | Software enable for accepting requests |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted | output | 1 | Request of the previous cycle set a new waiting bit |
| req_dropped | output | 1 | Request of the previous cycle was not taken |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data, low byte kept |
| int_valid | output | 1 | A vector is offered to the processor |
| int_vec | output | 8 | Offered vector, 0 when none |
| int_ack | input | 1 | Processor takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast_valid | output | 1 | A level-triggered vector was retired |
| eoi_bcast_vec | output | 8 | The retired level-triggered vector |
| ppr | output | 8 | Current processor priority |

## Verification
The hardest case to reach from the ports is a retirement whose broadcast depends on what happened earlier to the trigger bit. The stimulus has to leave a level-triggered vector waiting, send an edge-triggered duplicate to flip the bit, raise it into service past the task priority, and only then strobe end-of-interrupt. Nested service is another hard case: two vectors of different classes in service while a lower vector waits. The directed phase builds both. A long random phase then mixes acknowledges, end-of-interrupts, duplicate requests and task-priority writes in the same cycle. A behavioural model in the bench predicts every output on every clock.

// File: rtl/vpa_pkg.sv
// Package: shared widths and types of the vectored interrupt priority arbiter.
// Assumes 8-bit vectors, so every map covers 256 vectors.
package vpa_pkg;
    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CLS_W   = 4;
    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_VEC-1:0] vec_map_t;
endpackage

// File: rtl/vpa_hi_find.sv
// Highest-set-bit finder for a bitmap split into words.
// Each word gets its own local search (generate). The highest non-empty word then wins.
// Assumes N is a multiple of WORD_W and both are powers of two.
module vpa_hi_find #(
    parameter int N      = 256,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0]         map,
    output logic [$clog2(N)-1:0] idx,
    output logic                 none
);
    localparam int NW = N / WORD_W;
    localparam int BW = $clog2(WORD_W);
    localparam int WW = $clog2(NW);

    logic [NW-1:0]    word_any;
    logic [NW*BW-1:0] word_hi_flat;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [BW-1:0] hi_b;
        // purpose: highest set bit inside this word
        always_comb begin
            hi_b = '0;
            for (int b = 0; b < WORD_W; b++)
                if (map[w*WORD_W + b]) hi_b = BW'(b);
        end
        assign word_any[w] = |map[w*WORD_W +: WORD_W];
        assign word_hi_flat[w*BW +: BW] = hi_b;
    end

    // purpose: pick the highest non-empty word and join word and bit numbers
    always_comb begin
        none = ~|word_any;
        idx  = '0;
        for (int w = 0; w < NW; w++)
            if (word_any[w]) idx = {WW'(w), word_hi_flat[w*BW +: BW]};
    end
endmodule

// File: rtl/vpa_ppr_calc.sv
// Processor priority: task priority, or the class of the top in-service vector
// when that class is higher. Purely combinational.
module vpa_ppr_calc
    import vpa_pkg::*;
(
    input  vec_t tpr,
    input  vec_t isr_top,
    input  logic isr_none,
    output vec_t ppr
);
    vec_t isr_eff;

    // purpose: choose between task priority and in-service class
    always_comb begin
        isr_eff = isr_none ? '0 : isr_top;
        if (tpr[VEC_W-1 -: CLS_W] >= isr_eff[VEC_W-1 -: CLS_W])
            ppr = tpr;
        else
            ppr = {isr_eff[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
    end
endmodule

// File: rtl/vec_prio_arb.sv
// Vectored interrupt priority arbiter top.
// Holds the waiting, in-service and trigger maps and the task priority, and
// offers the highest deliverable vector. End-of-interrupt retires the top
// in-service vector. Assumes a single clock, a synchronous active-low reset,
// and that int_ack is only meaningful while int_valid is high.
module vec_prio_arb
    import vpa_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int MIN_VEC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_en,
    input  logic        sw_en,
    input  logic        req_valid,
    input  logic [7:0]  req_vec,
    input  logic        req_level,
    output logic        req_accepted,
    output logic        req_dropped,
    input  logic        tpr_wr,
    input  logic [31:0] tpr_wdata,
    output logic        int_valid,
    output logic [7:0]  int_vec,
    input  logic        int_ack,
    input  logic        eoi,
    output logic        eoi_bcast_valid,
    output logic [7:0]  eoi_bcast_vec,
    output logic [7:0]  ppr
);
    localparam int LOW_W = VEC_W - CLS_W;

    vec_map_t irr_q, isr_q, tmr_q;
    vec_map_t irr_d, isr_d, tmr_d;
    vec_t     tpr_q, tpr_d, ppr_q, ppr_d;
    vec_t     irr_top, isr_top, isrn_top;
    logic     irr_none, isr_none, isrn_none;
    logic     req_ok, was_pend, newly, take, retire, retire_lvl;

    vpa_hi_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
        .map(irr_q), .idx(irr_top), .none(irr_none));
    vpa_hi_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
        .map(isr_q), .idx(isr_top), .none(isr_none));
    vpa_hi_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isrn_find (
        .map(isr_d), .idx(isrn_top), .none(isrn_none));
    vpa_ppr_calc u_ppr (
        .tpr(tpr_d), .isr_top(isrn_top), .isr_none(isrn_none), .ppr(ppr_d));

    // purpose: offer the top waiting vector when its class beats the priority
    always_comb begin
        int_valid = !irr_none &&
                    ({irr_top[VEC_W-1 -: CLS_W], {LOW_W{1'b0}}} > ppr_q);
        int_vec   = int_valid ? irr_top : '0;
    end

    // purpose: decode request, acknowledge and retirement events
    always_comb begin
        req_ok     = req_valid && hw_en && sw_en && (req_vec >= vec_t'(MIN_VEC));
        was_pend   = irr_q[req_vec];
        newly      = req_ok && !was_pend;
        take       = int_ack && int_valid;
        retire     = eoi && !isr_none;
        retire_lvl = retire && tmr_q[isr_top];
    end

    // purpose: next state of the maps and task priority
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        tpr_d = tpr_q;
        if (take) begin
            isr_d[irr_top] = 1'b1;
            irr_d[irr_top] = 1'b0;
        end
        if (retire) begin
            isr_d[isr_top] = 1'b0;
            tmr_d[isr_top] = 1'b0;
        end
        if (newly) irr_d[req_vec] = 1'b1;
        if (newly && req_level)          tmr_d[req_vec] = 1'b1;
        else if (req_ok && !req_level)   tmr_d[req_vec] = 1'b0;
        if (tpr_wr) tpr_d = tpr_wdata[VEC_W-1:0];
    end

    // purpose: state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
            ppr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            tpr_q <= tpr_d;
            ppr_q <= ppr_d;
        end
    end

    // purpose: registered request response and retirement broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_accepted    <= 1'b0;
            req_dropped     <= 1'b0;
            eoi_bcast_valid <= 1'b0;
            eoi_bcast_vec   <= '0;
        end else begin
            req_accepted    <= newly;
            req_dropped     <= req_valid && !newly;
            eoi_bcast_valid <= retire_lvl;
            eoi_bcast_vec   <= retire_lvl ? isr_top : '0;
        end
    end

    assign ppr = ppr_q;
endmodule

// File: rtl/vpa_arb_chk.sv
// Checker for vec_prio_arb: port-level temporal properties, bound to the top.
module vpa_arb_chk #(
    parameter int MIN_VEC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_en,
    input logic        sw_en,
    input logic        req_valid,
    input logic [7:0]  req_vec,
    input logic        req_level,
    input logic        req_accepted,
    input logic        req_dropped,
    input logic        tpr_wr,
    input logic [31:0] tpr_wdata,
    input logic        int_valid,
    input logic [7:0]  int_vec,
    input logic        int_ack,
    input logic        eoi,
    input logic        eoi_bcast_valid,
    input logic [7:0]  eoi_bcast_vec,
    input logic [7:0]  ppr
);
    // R2
    resp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (req_accepted ^ req_dropped));
    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!req_accepted && !req_dropped));
    // R4
    low_vec_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vec < 8'(MIN_VEC)) |=> req_dropped);
    // R5
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(hw_en && sw_en)) |=> req_dropped);
    // R7
    offer_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> ({int_vec[7:4], 4'h0} > ppr));
    // R8
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_valid) |=> (ppr[7:4] >= $past(int_vec[7:4])));
    // R8
    ack_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_valid) |=> !(int_valid && int_vec == $past(int_vec)));
    // R6
    ppr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tpr_wr && !(int_ack && int_valid) && !eoi) |=> $stable(ppr));
    // R10
    bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi |=> !eoi_bcast_valid);
endmodule

bind vec_prio_arb vpa_arb_chk #(.MIN_VEC(MIN_VEC)) u_chk (.*);

// File: tb/tb_vec_prio_arb.sv
`timescale 1ns/1ps
module tb_vec_prio_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0, sw_en = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        tpr_wr = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        int_ack = 1'b0, eoi = 1'b0;
    logic        req_accepted, req_dropped, int_valid, eoi_bcast_valid;
    logic [7:0]  int_vec, eoi_bcast_vec, ppr;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    bit [255:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_ppr;

    always #2.5 clk = ~clk;

    vec_prio_arb dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    function automatic int hi_of(input bit [255:0] m);
        for (int i = 255; i >= 0; i--) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int prio_of(input int tpr, input bit [255:0] isr);
        int h = hi_of(isr);
        int iv = (h < 0) ? 0 : h;
        if ((tpr >> 4) >= (iv >> 4)) return tpr;
        return iv & 'hF0;
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_level = 0; req_vec = 0;
        tpr_wr = 0; tpr_wdata = 0; int_ack = 0; eoi = 0;
    endtask

    // one clock: check current outputs, advance the model, check registered outputs
    task automatic cycle();
        int h, rt, tag_i;
        bit ev, ok, newly, take, retire, bv;
        int bvec;
        string tag;
        #1;
        h  = hi_of(m_irr);
        ev = (h >= 0) && ((h & 'hF0) > m_ppr);
        chk(int_valid == ev, "R7", "int_valid", int_valid, ev);
        chk(int_vec == (ev ? h : 0), "R7", "int_vec", int_vec, ev ? h : 0);
        chk(ppr == m_ppr, "R6", "ppr", ppr, m_ppr);
        ok    = req_valid && hw_en && sw_en && (req_vec >= 16);
        newly = ok && !m_irr[req_vec];
        if (!req_valid) tag = "R2";
        else if (req_vec < 16) tag = "R4";
        else if (!(hw_en && sw_en)) tag = "R5";
        else if (m_irr[req_vec]) tag = "R3";
        else tag = "R2";
        take   = int_ack && ev;
        rt     = hi_of(m_isr);
        retire = eoi && (rt >= 0);
        bv     = retire && m_tmr[rt];
        bvec   = bv ? rt : 0;
        if (take) begin m_isr[h] = 1; m_irr[h] = 0; end
        if (retire) begin m_isr[rt] = 0; m_tmr[rt] = 0; end
        if (newly) m_irr[req_vec] = 1;
        if (newly && req_level) m_tmr[req_vec] = 1;
        else if (ok && !req_level) m_tmr[req_vec] = 0;
        if (tpr_wr) m_tpr = tpr_wdata & 'hFF;
        m_ppr = prio_of(m_tpr, m_isr);
        @(posedge clk);
        @(negedge clk);
        chk(req_accepted == newly, tag, "req_accepted", req_accepted, newly);
        chk(req_dropped == (req_valid && !newly), tag, "req_dropped",
            req_dropped, req_valid && !newly);
        chk(eoi_bcast_valid == bv, "R10", "bcast_valid", eoi_bcast_valid, bv);
        chk(eoi_bcast_vec == bvec, "R10", "bcast_vec", eoi_bcast_vec, bvec);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle_inputs();
        repeat (2) @(negedge clk);
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_ppr = 0;
        rst_n = 1;
        #1;
        // R1 state cleared
        chk(int_valid == 0, "R1", "int_valid after reset", int_valid, 0);
        chk(ppr == 0, "R1", "ppr after reset", ppr, 0);
        chk(eoi_bcast_valid == 0, "R1", "bcast after reset", eoi_bcast_valid, 0);
    endtask

    task automatic req(input int v, input bit lvl);
        req_valid = 1; req_vec = 8'(v); req_level = lvl; cycle();
    endtask
    task automatic wr_tpr(input int d);
        tpr_wr = 1; tpr_wdata = 32'(d); cycle();
    endtask
    task automatic ack();
        int_ack = 1; cycle();
    endtask
    task automatic end_int();
        eoi = 1; cycle();
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        hw_en = 1; sw_en = 1;
        req('h45, 0);                 // R2 new vector accepted
        req('h45, 1);                 // R3 duplicate dropped
        req('h0A, 1);                 // R4 reserved vector dropped
        sw_en = 0; req('h80, 1); sw_en = 1;   // R5 disabled
        hw_en = 0; req('h81, 0); hw_en = 1;   // R5 disabled
        req('h80, 1);
        wr_tpr('hFFFF_FF90);
        chk(ppr == 'h90, "R11", "ppr low byte kept", ppr, 'h90);
        wr_tpr('h0000_0075);
        ack();
        chk(ppr == 'h80, "R8", "ppr after ack", ppr, 'h80);
        req('h85, 0);                 // same class as in-service: held back
        end_int();
        chk(eoi_bcast_valid && eoi_bcast_vec == 'h80, "R10", "level retire bcast",
            eoi_bcast_vec, 'h80);
        ack();
        end_int();
        chk(eoi_bcast_valid == 0, "R10", "edge retire no bcast", eoi_bcast_valid, 0);
        end_int();                    // nothing in service
        chk(ppr == 'h75, "R9", "ppr after idle eoi", ppr, 'h75);
        // R3 edge duplicate clears the trigger bit
        wr_tpr(0);
        req('h60, 1);
        req('h60, 0);
        ack();
        end_int();
        chk(eoi_bcast_valid == 0, "R3", "trigger cleared by edge dup", eoi_bcast_valid, 0);
        // nested service
        req('h30, 1);
        req('h90, 1);
        ack();
        req('hA0, 0);
        ack();
        chk(ppr == 'hA0, "R8", "nested ppr", ppr, 'hA0);
        end_int();
        chk(ppr == 'h90, "R9", "ppr after first retire", ppr, 'h90);
        end_int();
        chk(eoi_bcast_vec == 'h90, "R9", "second retire bcast", eoi_bcast_vec, 'h90);
        // ack without offer ignored
        wr_tpr('hF0);
        ack();
        chk(ppr == 'hF0, "R8", "ack without offer", ppr, 'hF0);
        wr_tpr(0);
        // random mixing
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 2) != 0);
            req_vec   = 8'($urandom_range(0, 3) == 0 ? $urandom_range(0, 255)
                                                     : $urandom_range(8, 120));
            req_level = $urandom_range(0, 1);
            int_ack   = ($urandom_range(0, 2) == 0);
            eoi       = ($urandom_range(0, 3) == 0);
            tpr_wr    = ($urandom_range(0, 15) == 0);
            tpr_wdata = {$urandom_range(0, 'hFFFFFF), 8'($urandom_range(0, 'h5F))};
            hw_en     = ($urandom_range(0, 19) != 0);
            sw_en     = ($urandom_range(0, 19) != 0);
            cycle();
        end
        hw_en = 1; sw_en = 1;
        req('h70, 1);
        do_reset();                   // R1 reset with state present
        cycle();
        summary();
    end
endmodule